// File: doc/BRIEF.md
# Paged RAM-Disk Access Port

This block lets a CPU with an 8-bit I/O bus reach a byte-wide backing memory through a 24-bit address pointer. Software loads the pointer one byte at a time through three address ports. A data port then reads or writes the byte the pointer selects. After each data access the pointer advances, so a run of accesses walks through consecutive bytes of one 256-byte page.

The advance touches only the low pointer byte. At the end of a page it wraps back to the start of the same page, and software reloads the upper bytes to move to another page. A status port reports that the disk is fitted. The memory holds 2^DISK_AW bytes, which is 128 KiB when DISK_AW is 17. Any pointer value at or above that size falls outside the disk. Writes there are dropped and reads there return 0xFF.

Reads take one cycle: `io_rdata` changes on the clock edge that samples the read strobe, and it holds that value until the next read. The memory starts zero-filled in simulation and is not cleared by reset.

Top module: `ramdisk_port`

## Requirements
- R1: Reset clears the address pointer to zero and sets `io_rdata` to 0xFF.
- R2: Writes to offset 0, 1 and 2 load pointer bits 7:0, 15:8 and 23:16 in that order. Each write leaves the other two bytes unchanged.
- R3: A write to offset 3 stores `io_wdata` at the pointer when the pointer is below 2^DISK_AW.
- R4: A read at offset 3 returns the byte at the pointer on `io_rdata`, one clock after the read strobe is sampled.
- R5: Every read or write at offset 3 adds one to pointer bits 7:0, wrapping from 0xFF to 0x00. Bits 23:8 never change on that advance.
- R6: A write at offset 3 with the pointer at or above 2^DISK_AW changes no memory byte, and the pointer still advances.
- R7: A read at offset 3 with the pointer at or above 2^DISK_AW returns 0xFF, and the pointer still advances.
- R8: A read at offset 4 returns 0x7F. Bit 7 at zero means the disk is present.
- R9: Reads at offsets 0, 1, 2, 5, 6 and 7 return 0xFF. Writes at offsets 4 to 7 change neither the pointer nor the memory. A cycle with both strobes acts as a write only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | Port selected this cycle |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_off | input | 3 | Port offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |

## Verification
The hardest case to reach is an out-of-range write landing on an in-range byte. The memory is indexed by the low pointer bits only, so a dropped write would alias onto a real byte. The bench first fills such a byte with a known value. It then sets the top pointer byte to 1, writes at the same low bits, and reloads the pointer to read the byte back unchanged. After an out-of-range write it also reloads only the top byte. This shows that the pointer advanced during the dropped access: the next read must return the byte one above the original address.

// File: rtl/ramdisk_port.sv
module ramdisk_port #(
  parameter int DISK_AW = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_sel,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [2:0] io_off,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata
);
  localparam int PTR_W = 24;
  localparam int DEPTH = 1 << DISK_AW;
  localparam logic [2:0] OFF_DATA = 3'd3;
  localparam logic [2:0] OFF_STAT = 3'd4;
  localparam logic [7:0] STAT_VAL = 8'h7F;

  logic [PTR_W-1:0] ptr;
  logic [7:0]       mem [DEPTH];
  logic [7:0]       mem_q;
  logic             src_mem_q, src_stat_q;

  wire wr_go    = io_sel & io_wr;
  wire rd_go    = io_sel & io_rd & ~io_wr;
  wire data_acc = (wr_go | rd_go) && io_off == OFF_DATA;
  wire in_range = ptr[PTR_W-1:DISK_AW] == '0;
  wire [DISK_AW-1:0] idx = ptr[DISK_AW-1:0];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_go && io_off == 3'd0) begin
      ptr[7:0] <= io_wdata;
    end else if (wr_go && io_off == 3'd1) begin
      ptr[15:8] <= io_wdata;
    end else if (wr_go && io_off == 3'd2) begin
      ptr[23:16] <= io_wdata;
    end else if (data_acc) begin
      ptr[7:0] <= ptr[7:0] + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go && io_off == OFF_DATA && in_range) mem[idx] <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_go) mem_q <= mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_mem_q  <= 1'b0;
      src_stat_q <= 1'b0;
    end else if (rd_go) begin
      src_mem_q  <= io_off == OFF_DATA && in_range;
      src_stat_q <= io_off == OFF_STAT;
    end
  end

  assign io_rdata = src_mem_q  ? mem_q :
                    src_stat_q ? STAT_VAL : 8'hFF;
endmodule

// File: rtl/ramdisk_port_chk.sv
module ramdisk_port_chk #(
  parameter int DISK_AW = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_sel,
  input logic        io_wr,
  input logic        io_rd,
  input logic [2:0]  io_off,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic [23:0] ptr
);
  wire rd_go = io_sel && io_rd && !io_wr;
  wire dacc  = io_sel && (io_wr || io_rd) && io_off == 3'd3;

  assert_reset_ptr_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> ptr == 24'h0);

  assert_load_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel && io_wr && io_off == 3'd1 |=> ptr[15:8] == $past(io_wdata) && ptr[7:0] == $past(ptr[7:0]));

  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dacc |=> ptr[23:8] == $past(ptr[23:8]) && ptr[7:0] == 8'($past(ptr[7:0]) + 8'd1));

  assert_oob_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && io_off == 3'd3 && ptr[23:DISK_AW] != '0 |=> io_rdata == 8'hFF);

  assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && io_off == 3'd4 |=> io_rdata == 8'h7F);

  assert_unused_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && io_off != 3'd3 && io_off != 3'd4 |=> io_rdata == 8'hFF);

  assert_ignored_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel && io_wr && io_off >= 3'd4 |=> $stable(ptr));
endmodule

bind ramdisk_port ramdisk_port_chk #(.DISK_AW(DISK_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
  .io_off(io_off), .io_wdata(io_wdata), .io_rdata(io_rdata), .ptr(ptr)
);

// File: tb/tb_ramdisk_port.sv
module tb_ramdisk_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [2:0] io_off = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  ramdisk_port dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && io_sel && io_rd && !io_wr) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: unexpected read, got %02h expected none", io_rdata);
      end else begin
        check(io_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    io_sel = 1; io_wr = 1; io_rd = 0; io_off = off; io_wdata = d;
    @(negedge clk);
    io_sel = 0; io_wr = 0;
  endtask

  task automatic rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    io_sel = 1; io_rd = 1; io_wr = 0; io_off = off;
    @(negedge clk);
    io_sel = 0; io_rd = 0;
  endtask

  task automatic load(input logic [23:0] a);
    wr(3'd0, a[7:0]); wr(3'd1, a[15:8]); wr(3'd2, a[23:16]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(io_rdata, 8'hFF, "R1 reset read data");
    rst_n = 1;
    @(negedge clk);

    wr(3'd3, 8'hA5);
    load(24'h0);
    rd(3'd3, 8'hA5, "R1 pointer zero after reset / R3 / R4");

    load(24'h000010);
    wr(3'd3, 8'h11); wr(3'd3, 8'h22); wr(3'd3, 8'h33);
    load(24'h000010);
    rd(3'd3, 8'h11, "R4 read run byte0");
    rd(3'd3, 8'h22, "R5 advance byte1");
    rd(3'd3, 8'h33, "R5 advance byte2");

    load(24'h0001FE);
    wr(3'd3, 8'hC1); wr(3'd3, 8'hC2); wr(3'd3, 8'hC3);
    load(24'h000100);
    rd(3'd3, 8'hC3, "R5 wrap within page");
    load(24'h000200);
    rd(3'd3, 8'h00, "R5 no carry into bit 8");
    load(24'h0001FE);
    rd(3'd3, 8'hC1, "R3 page end byte");

    load(24'h000734);
    wr(3'd3, 8'h5A);
    load(24'h000734);
    rd(3'd3, 8'h5A, "R2 middle byte load");
    load(24'h000034);
    rd(3'd3, 8'h00, "R2 middle byte selects page");

    load(24'h010100);
    wr(3'd3, 8'h77);
    load(24'h000100);
    rd(3'd3, 8'hC3, "R6 out-of-range write dropped");

    load(24'h010010);
    wr(3'd3, 8'h99);
    wr(3'd2, 8'h00);
    rd(3'd3, 8'h22, "R6 pointer advances on dropped write");

    load(24'h000800);
    rd(3'd3, 8'hFF, "R7 read just past capacity");
    load(24'h050011);
    rd(3'd3, 8'hFF, "R7 read far out of range");
    wr(3'd2, 8'h00);
    rd(3'd3, 8'h33, "R7 pointer advances on out-of-range read");

    rd(3'd4, 8'h7F, "R8 status value");

    rd(3'd0, 8'hFF, "R9 address port read");
    rd(3'd6, 8'hFF, "R9 unused port read");
    load(24'h000010);
    wr(3'd5, 8'hEE); wr(3'd7, 8'h00); wr(3'd4, 8'h44);
    rd(3'd3, 8'h11, "R9 writes to unused ports ignored");

    io_sel = 1; io_wr = 1; io_rd = 1; io_off = 3'd3; io_wdata = 8'h66;
    @(negedge clk);
    io_sel = 0; io_wr = 0; io_rd = 0;
    load(24'h000011);
    rd(3'd3, 8'h66, "R9 both strobes act as write");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule